// File: doc/BRIEF.md
# Condition Flag Register and Execute Decision

This block keeps the four arithmetic flags (negative, zero, carry, overflow) and one sticky saturation flag for a processor pipeline. When the issuing instruction asks for a flag update, the block captures the flags from the ALU result, its carry-out and its signed-overflow indication on the next clock edge. At other times it holds them. The saturation flag is set by a separate strobe and stays set until it is cleared on purpose.

The same block also makes the execute-or-skip decision for a conditional instruction. It compares a 4-bit condition code against the flags already held in the register. The decision is purely combinational from the registered flags and the code, so a flag update in progress only affects instructions that come after it.

The data width and the structure of the zero detector are parameters. The zero detector is either a flat reduction or a two-level tree of chunk ORs.

Top module: `flag_unit`

## Requirements
- R1: While reset is held (active low) and after its release, all five flags read 0.
- R2: On an edge where the update strobe is high, the negative flag takes the top bit (bit DATA_W-1) of the result.
- R3: On an edge where the update strobe is high, the zero flag becomes 1 exactly when every result bit is 0.
- R4: On an edge where the update strobe is high, the carry flag takes the carry-out input and the overflow flag takes the signed-overflow input.
- R5: On an edge where the update strobe is low, the negative, zero, carry and overflow flags keep their values, whatever the result, carry and overflow inputs are.
- R6: The saturation flag is set by the saturation-set strobe whether or not the update strobe is high. Once set, it stays at 1 through any number of updates and idle cycles until it is cleared.
- R7: The clear strobe resets the saturation flag to 0 on the next edge. When set and clear are high on the same edge, the flag ends at 1.
- R8: The execute output is high when the condition code passes against the registered flags. The codes and their tests are: 0000 Z=1, 0001 Z=0, 0010 C=1, 0011 C=0, 0100 N=1, 0101 N=0, 0110 V=1, 0111 V=0.
- R9: Code 1110 always gives execute high. Codes 1000 through 1101 and code 1111 always give execute low.
- R10: The execute output uses only the flags stored before the current edge. An update requested in the same cycle changes the execute output only after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| result_i | input | DATA_W | ALU result |
| carry_i | input | 1 | Unsigned carry-out of the ALU |
| ovf_i | input | 1 | Signed overflow of the ALU |
| upd_i | input | 1 | Flag update strobe (instruction asks to set flags) |
| sat_set_i | input | 1 | Saturation event, sets the sticky flag |
| sat_clr_i | input | 1 | Explicit clear of the sticky flag |
| cond_i | input | 4 | Condition code of the instruction being decided |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_q_o | output | 1 | Sticky saturation flag |
| exec_o | output | 1 | 1 = execute, 0 = skip |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge. They also assume that the decision is read in the cycle its code is presented. They do not depend on how the strobes combine, because any mix of update, set and clear is legal.

The stimulus changes inputs only on falling edges. It drives set and clear together on purpose, and it sweeps all sixteen condition codes over several flag patterns. This keeps the stimulus inside those assumptions while still reaching the corner cases.

// File: rtl/flag_eval_pkg.sv
package flag_eval_pkg;

   localparam int CC_W = 4;

   typedef enum logic [CC_W-1:0] {
      CC_EQ = 4'h0,
      CC_NE = 4'h1,
      CC_CS = 4'h2,
      CC_CC = 4'h3,
      CC_MI = 4'h4,
      CC_PL = 4'h5,
      CC_VS = 4'h6,
      CC_VC = 4'h7,
      CC_AL = 4'hE
   } cc_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } arith_flags_t;

endpackage

// File: rtl/flag_zero_det.sv
module flag_zero_det #(
   parameter int DATA_W = 32,
   parameter bit USE_TREE = 1'b1,
   parameter int CHUNK_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              zero_o
);
   localparam int N_CHUNK = DATA_W / CHUNK_W;

   generate
      if (USE_TREE) begin : g_tree
         if (DATA_W % CHUNK_W != 0) begin : g_bad
            $error("flag_zero_det: DATA_W must be a multiple of CHUNK_W");
         end
         logic [N_CHUNK-1:0] chunk_any;
         for (genvar i = 0; i < N_CHUNK; i++) begin : g_chunk
            assign chunk_any[i] = |data_i[i*CHUNK_W +: CHUNK_W];
         end
         assign zero_o = ~|chunk_any;
      end else begin : g_flat
         assign zero_o = ~|data_i;
      end
   endgenerate

endmodule

// File: rtl/flag_arith_reg.sv
module flag_arith_reg
   import flag_eval_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit USE_TREE = 1'b1,
   parameter int CHUNK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] result_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   input  logic              upd_i,
   output arith_flags_t      flags_o
);
   localparam int MSB = DATA_W - 1;

   logic         res_zero;
   arith_flags_t flags_q;
   arith_flags_t flags_d;

   flag_zero_det #(
      .DATA_W  (DATA_W),
      .USE_TREE(USE_TREE),
      .CHUNK_W (CHUNK_W)
   ) u_zdet (
      .data_i(result_i),
      .zero_o(res_zero)
   );

   always_comb begin
      flags_d.n = result_i[MSB];
      flags_d.z = res_zero;
      flags_d.c = carry_i;
      flags_d.v = ovf_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (upd_i) begin
         flags_q <= flags_d;
      end
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/flag_sat_reg.sv
module flag_sat_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= 1'b0;
      end else if (set_i) begin
         q_r <= 1'b1;
      end else if (clr_i) begin
         q_r <= 1'b0;
      end
   end

   assign q_o = q_r;

endmodule

// File: rtl/flag_cond_eval.sv
module flag_cond_eval
   import flag_eval_pkg::*;
(
   input  logic [CC_W-1:0] cond_i,
   input  arith_flags_t    flags_i,
   output logic            pass_o
);
   always_comb begin
      case (cond_i)
         CC_EQ:   pass_o = flags_i.z;
         CC_NE:   pass_o = ~flags_i.z;
         CC_CS:   pass_o = flags_i.c;
         CC_CC:   pass_o = ~flags_i.c;
         CC_MI:   pass_o = flags_i.n;
         CC_PL:   pass_o = ~flags_i.n;
         CC_VS:   pass_o = flags_i.v;
         CC_VC:   pass_o = ~flags_i.v;
         CC_AL:   pass_o = 1'b1;
         default: pass_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
   import flag_eval_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit USE_TREE = 1'b1,
   parameter int CHUNK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] result_i,
   input  logic              carry_i,
   input  logic              ovf_i,
   input  logic              upd_i,
   input  logic              sat_set_i,
   input  logic              sat_clr_i,
   input  logic [CC_W-1:0]   cond_i,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic              flag_c_o,
   output logic              flag_v_o,
   output logic              flag_q_o,
   output logic              exec_o
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("flag_unit: DATA_W must be at least 2");
      end
      if (CHUNK_W < 1 || CHUNK_W > DATA_W) begin : g_bad_c
         $error("flag_unit: CHUNK_W out of range");
      end
   endgenerate

   arith_flags_t flags;

   flag_arith_reg #(
      .DATA_W  (DATA_W),
      .USE_TREE(USE_TREE),
      .CHUNK_W (CHUNK_W)
   ) u_arith (
      .clk     (clk),
      .rst_n   (rst_n),
      .result_i(result_i),
      .carry_i (carry_i),
      .ovf_i   (ovf_i),
      .upd_i   (upd_i),
      .flags_o (flags)
   );

   flag_sat_reg u_sat (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(sat_set_i),
      .clr_i(sat_clr_i),
      .q_o  (flag_q_o)
   );

   flag_cond_eval u_cond (
      .cond_i (cond_i),
      .flags_i(flags),
      .pass_o (exec_o)
   );

   assign flag_n_o = flags.n;
   assign flag_z_o = flags.z;
   assign flag_c_o = flags.c;
   assign flag_v_o = flags.v;

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] result_i,
   input logic              carry_i,
   input logic              ovf_i,
   input logic              upd_i,
   input logic              sat_set_i,
   input logic              sat_clr_i,
   input logic [3:0]        cond_i,
   input logic              flag_n_o,
   input logic              flag_z_o,
   input logic              flag_c_o,
   input logic              flag_v_o,
   input logic              flag_q_o,
   input logic              exec_o
);
   logic [3:0] nzcv;
   assign nzcv = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};

   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (nzcv == 4'b0 && !flag_q_o)); // R1
   AST_N_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> flag_n_o == $past(result_i[DATA_W-1])); // R2
   AST_Z_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> flag_z_o == ($past(result_i) == '0)); // R3
   AST_CV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (flag_c_o == $past(carry_i) && flag_v_o == $past(ovf_i))); // R4
   AST_NZCV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(nzcv)); // R5
   AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q_o && !sat_clr_i) |=> flag_q_o); // R6
   AST_Q_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q_o && !sat_set_i) |=> !flag_q_o); // R6
   AST_Q_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sat_set_i |=> flag_q_o); // R7
   AST_Q_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr_i && !sat_set_i) |=> !flag_q_o); // R7
   AST_EQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i == 4'h0 |-> exec_o == flag_z_o); // R8
   AST_CS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i == 4'h2 |-> exec_o == flag_c_o); // R8
   AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i == 4'hE |-> exec_o); // R9
   AST_UNDEF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i[3] && cond_i != 4'hE) |-> !exec_o); // R9

endmodule

bind flag_unit flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .result_i (result_i),
   .carry_i  (carry_i),
   .ovf_i    (ovf_i),
   .upd_i    (upd_i),
   .sat_set_i(sat_set_i),
   .sat_clr_i(sat_clr_i),
   .cond_i   (cond_i),
   .flag_n_o (flag_n_o),
   .flag_z_o (flag_z_o),
   .flag_c_o (flag_c_o),
   .flag_v_o (flag_v_o),
   .flag_q_o (flag_q_o),
   .exec_o   (exec_o)
);

// File: tb/tb_flag_unit.sv
`timescale 1ns/1ps
module tb_flag_unit;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] result_i = '0;
   logic              carry_i = 1'b0, ovf_i = 1'b0, upd_i = 1'b0;
   logic              sat_set_i = 1'b0, sat_clr_i = 1'b0;
   logic [3:0]        cond_i = 4'hF;
   logic              flag_n_o, flag_z_o, flag_c_o, flag_v_o, flag_q_o, exec_o;

   int checks = 0;
   int bad = 0;
   bit m_n = 0, m_z = 0, m_c = 0, m_v = 0, m_q = 0;

   always #(CLK_P/2) clk = ~clk;

   flag_unit #(.DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .result_i(result_i), .carry_i(carry_i),
      .ovf_i(ovf_i), .upd_i(upd_i), .sat_set_i(sat_set_i), .sat_clr_i(sat_clr_i),
      .cond_i(cond_i), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
      .flag_c_o(flag_c_o), .flag_v_o(flag_v_o), .flag_q_o(flag_q_o), .exec_o(exec_o)
   );

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic bit cond_exp(logic [3:0] cc);
      case (cc)
         4'h0: return m_z;
         4'h1: return !m_z;
         4'h2: return m_c;
         4'h3: return !m_c;
         4'h4: return m_n;
         4'h5: return !m_n;
         4'h6: return m_v;
         4'h7: return !m_v;
         4'hE: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check_flags(string tag);
      chk({tag, " N"}, flag_n_o, m_n);
      chk({tag, " Z"}, flag_z_o, m_z);
      chk({tag, " C"}, flag_c_o, m_c);
      chk({tag, " V"}, flag_v_o, m_v);
      chk({tag, " Q"}, flag_q_o, m_q);
   endtask

   // apply one cycle of stimulus at a falling edge, model the capturing edge
   task automatic step(logic [DATA_W-1:0] r, logic c, logic v, logic u, logic qs, logic qc);
      result_i = r; carry_i = c; ovf_i = v; upd_i = u; sat_set_i = qs; sat_clr_i = qc;
      @(posedge clk);
      if (u) begin
         m_n = r[DATA_W-1]; m_z = (r == '0); m_c = c; m_v = v;
      end
      if (qs) m_q = 1'b1;
      else if (qc) m_q = 1'b0;
      @(negedge clk);
      upd_i = 1'b0; sat_set_i = 1'b0; sat_clr_i = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check_flags("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_flags("R1 after reset");
   endtask

   task automatic t_update();
      step(32'h8000_0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      check_flags("R2 R4 negative nonzero");
      step(32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check_flags("R3 R4 zero result");
      step(32'h0000_0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      check_flags("R3 single bit nonzero");
      step(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check_flags("R2 all ones");
   endtask

   task automatic t_hold();
      step(32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      step(32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check_flags("R5 hold zero in");
      step(32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check_flags("R5 hold pattern in");
   endtask

   task automatic t_sticky();
      step(32'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      check_flags("R6 set without update");
      for (int i = 0; i < 3; i++) step(32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check_flags("R6 sticky over updates");
      step(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      check_flags("R7 clear");
      step(32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      check_flags("R7 set beats clear");
      step(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      check_flags("R7 clear again");
   endtask

   task automatic t_conds();
      logic [DATA_W-1:0] pats [4] = '{32'h0, 32'h8000_0000, 32'h0000_0005, 32'h8000_0000};
      logic cs [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
      logic vs [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
      for (int p = 0; p < 4; p++) begin
         step(pats[p], cs[p], vs[p], 1'b1, 1'b0, 1'b0);
         for (int cc = 0; cc < 16; cc++) begin
            cond_i = 4'(cc);
            #1;
            if (cc < 8) chk($sformatf("R8 code %0d pattern %0d", cc, p), exec_o, cond_exp(4'(cc)));
            else chk($sformatf("R9 code %0d pattern %0d", cc, p), exec_o, cond_exp(4'(cc)));
         end
      end
   endtask

   task automatic t_registered();
      step(32'h1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      cond_i = 4'h0;
      result_i = '0; upd_i = 1'b1;
      #1;
      chk("R10 EQ before capturing edge", exec_o, 1'b0);
      @(posedge clk);
      m_z = 1'b1; m_n = 1'b0; m_c = 1'b0; m_v = 1'b0;
      @(negedge clk);
      upd_i = 1'b0;
      chk("R10 EQ after capturing edge", exec_o, 1'b1);
   endtask

   initial begin
      t_reset();
      t_update();
      t_hold();
      t_sticky();
      t_conds();
      t_registered();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule